// File: doc/BRIEF.md
# Interrupt Request Collector

This block gathers interrupt requests from a chip's peripherals into one line to the host processor. There are two kinds of request input. Four of them are the summary requests of the GPIO banks, each of which already does its own per-pin masking. The other six come from the remaining peripheral sources. Every request is registered into a 10-bit status word. The GPIO bank summaries sit in the low bits, and the other sources fill the bits above them in ascending order. The host reads that word through a small register port. Any nonzero value in it means work is pending.

Software controls the collector through a mask register. This register holds one enable bit for each non-GPIO source, where 1 means enabled, together with a global enable bit that software sets during initialisation. The host interrupt line rises when the global enable is set and at least one pending request is enabled. The GPIO bank bits count as always enabled at this level.

The host detects interrupts on rising edges. For that reason, each read of the status register acts as the end of a service pass. After such a read the line goes low for one cycle. If a request is still pending, the line then rises again, so the host sees a fresh edge.

Top module: `irq_gather`

## Requirements
- R1: Status register (reg_sel=0) reads bit i = bank_req[i] for i in 0..3 and bit 4+j = periph_req[j] for j in 0..5, as sampled at the previous rising clock edge; bits 15..10 read 0. The status shows raw requests, unaffected by the mask.
- R2: A write with reg_wr=1 and reg_sel=1 loads the mask register. Bits 5..0 are the enables for periph_req[5..0] (1 = enabled), and bit 15 is the global enable. When the mask register is read back (reg_sel=1), bits 14..6 read 0.
- R3: After reset the status word is 0, the mask register is 0 and host_irq is low.
- R4: While the global enable bit is 0, host_irq stays low (from the cycle after the bit is cleared), whatever the requests.
- R5: A pending GPIO bank bit drives host_irq high whatever the values of mask bits 5..0, provided the global enable is set.
- R6: A pending non-GPIO source drives host_irq only when its mask enable bit is 1. If only disabled sources are pending, host_irq stays low.
- R7: host_irq is registered. A request rising at a clock edge, with the global enable and the request's own enable already set, makes host_irq high after the second edge.
- R8: A status read (reg_rd=1, reg_sel=0) sampled at edge E forces host_irq low after edge E+1 for exactly one cycle. If a request is still pending, host_irq is high again after edge E+2.
- R9: When all enabled requests clear, host_irq falls. A status read with nothing pending leaves host_irq low.
- R10: Writes with reg_sel=0 change nothing: the status register is read-only and the mask register keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bank_req | input | 4 | Summary requests of the GPIO banks |
| periph_req | input | 6 | Requests from the other peripheral sources |
| reg_rd | input | 1 | Read strobe of the register port |
| reg_wr | input | 1 | Write strobe of the register port |
| reg_sel | input | 1 | Register select: 0 status, 1 mask |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register |
| host_irq | output | 1 | Interrupt line to the host, detected on rising edges |

## Verification
The bench makes a status read in the very cycle a new request arrives or the mask is rewritten. In that cycle the forced low gap of the service pass has to merge correctly with the pending state, whether the request has just appeared or was just enabled. A behavioural model runs every cycle and predicts, for each such collision, the one-cycle dip and the re-rise that follows. The bench compares the line and the selected register against that model. Directed checks pin down the exact cycles of the gap and of the re-rise.

// File: rtl/irq_gather.sv
module irq_gather #(
  parameter int BANKS  = 4,
  parameter int OTHERS = 6,
  parameter int DW     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANKS-1:0]  bank_req,
  input  logic [OTHERS-1:0] periph_req,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              host_irq
);
  localparam int SRCS = BANKS + OTHERS;
  localparam int GEN  = DW - 1;

  logic [SRCS-1:0]   stat_q;
  logic [OTHERS-1:0] en_q;
  logic              gen_q;
  logic              gap_q;
  logic              irq_q;
  logic              pend;
  logic [DW-1:0]     stat_word;
  logic [DW-1:0]     mask_word;

  wire unused_wdata = ^reg_wdata[GEN-1:OTHERS];

  assign pend = (|stat_q[BANKS-1:0]) | (|(stat_q[SRCS-1:BANKS] & en_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      en_q   <= '0;
      gen_q  <= 1'b0;
      gap_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= {periph_req, bank_req};
      gap_q  <= reg_rd & ~reg_sel;
      irq_q  <= gen_q & pend & ~gap_q;
      if (reg_wr && reg_sel) begin
        en_q  <= reg_wdata[OTHERS-1:0];
        gen_q <= reg_wdata[GEN];
      end
    end
  end

  always_comb begin
    stat_word = '0;
    stat_word[SRCS-1:0] = stat_q;
    mask_word = '0;
    mask_word[OTHERS-1:0] = en_q;
    mask_word[GEN] = gen_q;
  end

  assign reg_rdata = reg_sel ? mask_word : stat_word;
  assign host_irq  = irq_q;
endmodule

// File: rtl/irq_gather_chk.sv
module irq_gather_chk #(
  parameter int BANKS  = 4,
  parameter int OTHERS = 6
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [BANKS-1:0]         bank_req,
  input logic [OTHERS-1:0]        periph_req,
  input logic                     reg_rd,
  input logic                     reg_sel,
  input logic [BANKS+OTHERS-1:0]  stat_q,
  input logic [OTHERS-1:0]        en_q,
  input logic                     gen_q,
  input logic                     gap_q,
  input logic                     host_irq
);
  // R1
  stat_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> stat_q == $past({periph_req, bank_req}));

  // R4
  gen_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_q |=> !host_irq);

  // R5
  bank_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_q && (|stat_q[BANKS-1:0]) && !gap_q) |=> host_irq);

  // R6
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[BANKS-1:0] == '0 && (stat_q[BANKS+OTHERS-1:BANKS] & en_q) == '0) |=> !host_irq);

  // R8
  service_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !reg_sel) |=> ##1 !host_irq);
endmodule

bind irq_gather irq_gather_chk #(.BANKS(BANKS), .OTHERS(OTHERS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bank_req(bank_req), .periph_req(periph_req),
  .reg_rd(reg_rd), .reg_sel(reg_sel), .stat_q(stat_q), .en_q(en_q),
  .gen_q(gen_q), .gap_q(gap_q), .host_irq(host_irq)
);

// File: tb/test_irq_gather.sv
module test_irq_gather;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bank_req = '0;
  logic [5:0]  periph_req = '0;
  logic        reg_rd = 1'b0, reg_wr = 1'b0, reg_sel = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        host_irq;

  int checks = 0, errors = 0;

  int m_stat = 0, m_mask = 0;
  bit m_gap = 0, m_irq = 0;

  irq_gather i_irq_gather (
    .clk(clk), .rst_n(rst_n), .bank_req(bank_req), .periph_req(periph_req),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .host_irq(host_irq)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stat = 0; m_mask = 0; m_gap = 0; m_irq = 0;
    end else begin
      bit pending;
      pending = ((m_stat & 'hF) != 0) || (((m_stat >> 4) & m_mask & 'h3F) != 0);
      m_irq = m_mask[15] && pending && !m_gap;
      m_gap = reg_rd && !reg_sel;
      m_stat = {periph_req, bank_req};
      if (reg_wr && reg_sel) m_mask = reg_wdata & 'h803F;
    end
  end

  always @(posedge clk) begin
    #(PERIOD/4);
    if (rst_n) begin
      check("R7 model irq", host_irq, m_irq);
      if (reg_sel) check("R2 model mask", reg_rdata, m_mask);
      else         check("R1 model status", reg_rdata, m_stat);
    end
  end

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic wr_reg(bit sel, logic [15:0] d);
    @(negedge clk);
    reg_wr = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0; reg_sel = 0; #1;
  endtask

  task automatic peek_mask(int exp, string tag);
    reg_sel = 1; #1; check(tag, reg_rdata, exp); reg_sel = 0; #1;
  endtask

  initial begin
    #(PERIOD*200000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);
    check("R3 reset irq", host_irq, 0);
    check("R3 reset status", reg_rdata, 0);
    peek_mask(0, "R3 reset mask");

    wr_reg(1, 16'h7FF4);
    peek_mask('h0034, "R2 mask readback");
    wr_reg(0, 16'hFFFF);
    peek_mask('h0034, "R10 mask kept after status write");
    check("R10 status unchanged", reg_rdata, 0);

    @(negedge clk); bank_req = 4'b0010;
    tick(1); check("R1 status bank", reg_rdata, 'h002);
    tick(2); check("R4 no irq with global off", host_irq, 0);

    wr_reg(1, 16'h8000);
    tick(1); check("R5 bank fires with source enables clear", host_irq, 1);

    @(negedge clk); reg_rd = 1; reg_sel = 0;
    @(negedge clk); reg_rd = 0; #1;
    check("R8 still high after read edge", host_irq, 1);
    tick(1); check("R8 gap low", host_irq, 0);
    tick(1); check("R8 re-rise", host_irq, 1);

    @(negedge clk); bank_req = 0; periph_req = 6'b000100;
    tick(2); check("R6 disabled source quiet", host_irq, 0);
    check("R1 status raw periph", reg_rdata, 'h040);
    wr_reg(1, 16'h8001);
    tick(1); check("R6 other enable quiet", host_irq, 0);
    wr_reg(1, 16'h8004);
    tick(1); check("R6 enabled source fires", host_irq, 1);

    @(negedge clk); periph_req = 0;
    tick(2); check("R9 falls when clear", host_irq, 0);
    @(negedge clk); reg_rd = 1;
    @(negedge clk); reg_rd = 0;
    tick(2); check("R9 read with nothing pending", host_irq, 0);

    @(negedge clk); bank_req = 4'b1000; #1;
    tick(1); check("R7 one edge later still low", host_irq, 0);
    tick(1); check("R7 two edges later high", host_irq, 1);

    // collision: status read in the same cycle as a new request
    @(negedge clk); bank_req = 0; tick(3);
    @(negedge clk); periph_req = 6'b000100; reg_rd = 1;
    @(negedge clk); reg_rd = 0; periph_req = 6'b000100;
    tick(3); check("R8 collision settles high", host_irq, 1);

    wr_reg(1, 16'h0004);
    tick(1); check("R4 global cleared", host_irq, 0);

    @(negedge clk); periph_req = 0; bank_req = 4'b0101;
    tick(1); check("R1 status multi bank", reg_rdata, 'h005);

    tick(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule